// File: doc/BRIEF.md
# Self-Clearing Domain Reset Sequencer

This block drives the active-low reset lines of four clock domains and one memory interface from a single control register. Software starts a reset of the main core, of core0 or of the core debug logic by writing 1 to that domain's command bit. The block holds the domain in reset for a fixed number of cycles and then clears the bit by itself. A command bit that reads back as 0 therefore tells software that its reset has finished. The debug domain can also be reset by a power-gating event unless a mask bit suppresses that path.

The memory interface reset is a plain level that software sets and later clears. The peripheral power-mix domain is reset by a hardware power-up trigger. Its pulse width is (code+1) times a base unit of 88 cycles, where code is a 2-bit field of the register read at the moment the trigger arrives.

Each core domain runs a two-state machine. In IDLE the domain reset is released. IDLE goes to HOLD on a start. HOLD drives the reset low and goes back to IDLE when its terminal count is reached. The mix domain has the same shape with states IDLE and STRETCH: IDLE goes to STRETCH on the trigger, and STRETCH goes back to IDLE at the latched terminal count.

Top module: `dom_rst_seq`

## Requirements
- R1: After reset every domain reset output is high (released) and `rd_data` reads 0.
- R2: A write with bit 0 set starts a main-core reset: `rst_main_n` is low from the cycle after the write for exactly 16 cycles. Bit 1 does the same for `rst_core0_n`, and bit 2 does the same for `rst_dbg_n`.
- R3: Read bits 0, 1 and 2 each read 1 while the matching pulse is running and 0 once it has ended (self-clear).
- R4: A command written while that domain's pulse is running is ignored and does not restart the count. Writing 0 to a command bit never cuts a pulse short.
- R5: The three core domains are independent, and one write with several command bits set starts all of them in the same cycle.
- R6: Bit 3 is a level: `rst_mem_n` equals the inverse of the last written bit 3. It is never cleared by hardware.
- R7: A `pwr_up_trig` pulse while the mix domain is idle drives `rst_mix_n` low for (code+1)×88 cycles, where code is bits 5:4. This gives 88, 176, 264 or 352 cycles.
- R8: The code is taken from the register value held before the trigger's clock edge. A write in the same cycle as the trigger, or during the pulse, takes effect only on the next pulse.
- R9: A trigger that arrives while the mix pulse is running is ignored.
- R10: When bit 6 (mask) is 0, `pg_event` starts a debug pulse as in R2. When it is 1, `pg_event` has no effect. The mask in force is the one held before the clock edge.
- R11: `rd_data` has this layout: bit 0 main busy, bit 1 core0 busy, bit 2 debug busy, bit 3 memory level, bits 5:4 mix code, bit 6 debug mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 7 | Register write value |
| rd_data | output | 7 | Register read value |
| pwr_up_trig | input | 1 | Mix-domain power-up trigger |
| pg_event | input | 1 | Power-gating event for the debug domain |
| rst_main_n | output | 1 | Main core reset, active low |
| rst_core0_n | output | 1 | Core0 reset, active low |
| rst_dbg_n | output | 1 | Core debug reset, active low |
| rst_mix_n | output | 1 | Power-mix reset, active low |
| rst_mem_n | output | 1 | Memory interface reset, active low |

## Verification
Two pairs of functions can land on the same clock edge. In the first, a register write that changes the mix code coincides with a power-up trigger. In the second, a write that flips the debug mask coincides with a power-gating event. The bench drives each pair in one cycle, in both directions of the mask change and with the code changed both at the trigger and mid-pulse. Its behavioural model always uses the register value held before the edge, and it judges the resulting pulse widths and the presence or absence of a debug pulse on every clock.

// File: rtl/dom_rst_pkg.sv
package dom_rst_pkg;
    typedef enum logic {PU_IDLE, PU_HOLD} pulse_st_e;
    typedef enum logic {MX_IDLE, MX_STRETCH} mix_st_e;

    localparam int unsigned BIT_MAIN    = 0;
    localparam int unsigned BIT_CORE0   = 1;
    localparam int unsigned BIT_DBG     = 2;
    localparam int unsigned BIT_MEM     = 3;
    localparam int unsigned BIT_CODE_LO = 4;
    localparam int unsigned N_CORE_DOM  = 3;
endpackage

// File: rtl/dom_pulse_unit.sv
module dom_pulse_unit
    import dom_rst_pkg::*;
#(
    parameter int unsigned LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic rst_out_n
);
    localparam int unsigned CW = $clog2(LEN + 1);
    localparam logic [CW-1:0] LAST = CW'(LEN - 1);

    pulse_st_e     st_q;
    logic [CW-1:0] cnt_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= PU_IDLE;
            cnt_q <= '0;
        end else begin
            unique case (st_q)
                PU_IDLE: begin
                    if (start) begin
                        st_q  <= PU_HOLD;
                        cnt_q <= '0;
                    end
                end
                PU_HOLD: begin
                    if (cnt_q == LAST) st_q <= PU_IDLE;
                    else               cnt_q <= cnt_q + 1'b1;
                end
                default: st_q <= PU_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (st_q)
            PU_HOLD: begin busy = 1'b1; rst_out_n = 1'b0; end
            default: begin busy = 1'b0; rst_out_n = 1'b1; end
        endcase
    end
endmodule

// File: rtl/dom_mix_stretch.sv
module dom_mix_stretch
    import dom_rst_pkg::*;
#(
    parameter int unsigned UNIT   = 88,
    parameter int unsigned CODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig,
    input  logic [CODE_W-1:0] code,
    output logic              rst_out_n
);
    localparam int unsigned MAXLEN = UNIT * (2 ** CODE_W);
    localparam int unsigned CW     = $clog2(MAXLEN + 1);

    mix_st_e       st_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last_q;

    // state register; width latched on entry to STRETCH
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= MX_IDLE;
            cnt_q  <= '0;
            last_q <= '0;
        end else begin
            unique case (st_q)
                MX_IDLE: begin
                    if (trig) begin
                        st_q   <= MX_STRETCH;
                        cnt_q  <= '0;
                        last_q <= CW'((int'(code) + 1) * UNIT - 1);
                    end
                end
                MX_STRETCH: begin
                    if (cnt_q == last_q) st_q <= MX_IDLE;
                    else                 cnt_q <= cnt_q + 1'b1;
                end
                default: st_q <= MX_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (st_q)
            MX_STRETCH: rst_out_n = 1'b0;
            default:    rst_out_n = 1'b1;
        endcase
    end
endmodule

// File: rtl/dom_rst_seq.sv
module dom_rst_seq
    import dom_rst_pkg::*;
#(
    parameter int unsigned CORE_CYC = 16,
    parameter int unsigned MIX_UNIT = 88,
    parameter int unsigned CODE_W   = 2,
    localparam int unsigned BIT_MASK = BIT_CODE_LO + CODE_W,
    localparam int unsigned CTRL_W   = BIT_MASK + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic [CTRL_W-1:0] rd_data,
    input  logic              pwr_up_trig,
    input  logic              pg_event,
    output logic              rst_main_n,
    output logic              rst_core0_n,
    output logic              rst_dbg_n,
    output logic              rst_mix_n,
    output logic              rst_mem_n
);
    logic              mem_q;
    logic              mask_q;
    logic [CODE_W-1:0] code_q;
    logic [N_CORE_DOM-1:0] start;
    logic [N_CORE_DOM-1:0] busy;
    logic [N_CORE_DOM-1:0] dom_n;

    // level fields of the control register (R6, R8, R10)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q  <= 1'b0;
            mask_q <= 1'b0;
            code_q <= '0;
        end else if (wr_en) begin
            mem_q  <= wr_data[BIT_MEM];
            mask_q <= wr_data[BIT_MASK];
            code_q <= wr_data[BIT_CODE_LO +: CODE_W];
        end
    end

    always_comb begin
        start[BIT_MAIN]  = wr_en & wr_data[BIT_MAIN];
        start[BIT_CORE0] = wr_en & wr_data[BIT_CORE0];
        start[BIT_DBG]   = (wr_en & wr_data[BIT_DBG]) | (pg_event & ~mask_q);
    end

    for (genvar g = 0; g < N_CORE_DOM; g++) begin : g_core
        dom_pulse_unit #(.LEN(CORE_CYC)) u_pulse (
            .clk       (clk),
            .rst_n     (rst_n),
            .start     (start[g]),
            .busy      (busy[g]),
            .rst_out_n (dom_n[g])
        );
    end

    dom_mix_stretch #(.UNIT(MIX_UNIT), .CODE_W(CODE_W)) u_mix (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig      (pwr_up_trig),
        .code      (code_q),
        .rst_out_n (rst_mix_n)
    );

    assign rst_main_n  = dom_n[BIT_MAIN];
    assign rst_core0_n = dom_n[BIT_CORE0];
    assign rst_dbg_n   = dom_n[BIT_DBG];
    assign rst_mem_n   = ~mem_q;
    assign rd_data     = {mask_q, code_q, mem_q, busy};
endmodule

// File: rtl/dom_rst_seq_chk.sv
module dom_rst_seq_chk #(
    parameter int unsigned CORE_CYC = 16,
    parameter int unsigned MIX_UNIT = 88,
    parameter int unsigned CODE_W   = 2
) (
    input logic clk,
    input logic rst_n,
    input logic wr_en,
    input logic cmd_main,
    input logic cmd_dbg,
    input logic mem_bit,
    input logic mask_rd,
    input logic busy_main,
    input logic pwr_up_trig,
    input logic pg_event,
    input logic rst_main_n,
    input logic rst_dbg_n,
    input logic rst_mix_n,
    input logic rst_mem_n
);
    localparam int unsigned MAXLEN = MIX_UNIT * (2 ** CODE_W);

    int unsigned lo_main;
    int unsigned lo_mix;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_main <= 0;
            lo_mix  <= 0;
        end else begin
            lo_main <= rst_main_n ? 0 : lo_main + 1;
            lo_mix  <= rst_mix_n  ? 0 : lo_mix + 1;
        end
    end

    p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cmd_main && rst_main_n) |=> !rst_main_n);
    p_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_main_n) |-> (lo_main == CORE_CYC));
    p_norestart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_main_n |-> (lo_main < CORE_CYC));
    p_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_main_n |-> busy_main);
    p_selfclear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_main_n) |-> !busy_main);
    p_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rst_mem_n == !$past(mem_bit)));
    p_trig_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_up_trig && rst_mix_n) |=> !rst_mix_n);
    p_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_mix_n |-> (lo_mix < MAXLEN));
    p_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pg_event && mask_rd && rst_dbg_n && !(wr_en && cmd_dbg)) |=> rst_dbg_n);
    p_pgate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pg_event && !mask_rd && rst_dbg_n) |=> !rst_dbg_n);
endmodule

bind dom_rst_seq dom_rst_seq_chk #(
    .CORE_CYC(CORE_CYC), .MIX_UNIT(MIX_UNIT), .CODE_W(CODE_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .cmd_main    (wr_data[0]),
    .cmd_dbg     (wr_data[2]),
    .mem_bit     (wr_data[3]),
    .mask_rd     (rd_data[CTRL_W-1]),
    .busy_main   (rd_data[0]),
    .pwr_up_trig (pwr_up_trig),
    .pg_event    (pg_event),
    .rst_main_n  (rst_main_n),
    .rst_dbg_n   (rst_dbg_n),
    .rst_mix_n   (rst_mix_n),
    .rst_mem_n   (rst_mem_n)
);

// File: tb/sim_dom_rst_seq.sv
module sim_dom_rst_seq;
    localparam int CORE = 16;
    localparam int UNIT = 88;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [6:0] wr_data = '0;
    logic [6:0] rd_data;
    logic       pwr_up_trig = 1'b0;
    logic       pg_event = 1'b0;
    logic       rst_main_n, rst_core0_n, rst_dbg_n, rst_mix_n, rst_mem_n;

    int total = 0;
    int bad = 0;
    string cur = "R1";

    // behavioural reference state: remaining low cycles per domain
    int m_main = 0, m_c0 = 0, m_dbg = 0, m_mix = 0;
    int m_code = 0;
    bit m_mem = 0, m_mask = 0;

    always #2 clk = ~clk;

    dom_rst_seq u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .pwr_up_trig(pwr_up_trig), .pg_event(pg_event),
        .rst_main_n(rst_main_n), .rst_core0_n(rst_core0_n),
        .rst_dbg_n(rst_dbg_n), .rst_mix_n(rst_mix_n), .rst_mem_n(rst_mem_n)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s/%s %s: actual=%0d expected=%0d", cur, req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        logic [6:0] exp_rd;
        exp_rd = {m_mask, 2'(m_code), m_mem, m_dbg > 0, m_c0 > 0, m_main > 0};
        chk(rst_main_n == (m_main == 0), "R2", "rst_main_n", rst_main_n, m_main == 0);
        chk(rst_core0_n == (m_c0 == 0), "R5", "rst_core0_n", rst_core0_n, m_c0 == 0);
        chk(rst_dbg_n == (m_dbg == 0), "R10", "rst_dbg_n", rst_dbg_n, m_dbg == 0);
        chk(rst_mix_n == (m_mix == 0), "R7", "rst_mix_n", rst_mix_n, m_mix == 0);
        chk(rst_mem_n == !m_mem, "R6", "rst_mem_n", rst_mem_n, !m_mem);
        chk(rd_data == exp_rd, "R3", "rd_data", rd_data, exp_rd);
    endtask

    // model of one clock edge; uses the register fields held before the edge
    task automatic model_edge(input bit we, input logic [6:0] d, input bit tr, input bit pg);
        if (m_main > 0) m_main--; else if (we && d[0]) m_main = CORE;
        if (m_c0 > 0)   m_c0--;   else if (we && d[1]) m_c0 = CORE;
        if (m_dbg > 0)  m_dbg--;  else if ((we && d[2]) || (pg && !m_mask)) m_dbg = CORE;
        if (m_mix > 0)  m_mix--;  else if (tr) m_mix = (m_code + 1) * UNIT;
        if (we) begin
            m_mem  = d[3];
            m_code = int'(d[5:4]);
            m_mask = d[6];
        end
    endtask

    task automatic step(input bit we, input logic [6:0] d, input bit tr, input bit pg);
        wr_en = we; wr_data = d; pwr_up_trig = tr; pg_event = pg;
        @(posedge clk);
        model_edge(we, d, tr, pg);
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0; pwr_up_trig = 1'b0; pg_event = 1'b0;
        compare_all();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        cur = "R1";                     // reset state
        compare_all();
        rst_n = 1'b1;
        idle(2);

        cur = "R2";                     // single main-core pulse, 16 cycles
        step(1'b1, 7'h01, 1'b0, 1'b0);
        idle(20);

        cur = "R4";                     // re-issue and zero-write mid pulse
        step(1'b1, 7'h01, 1'b0, 1'b0);
        idle(5);
        step(1'b1, 7'h01, 1'b0, 1'b0);
        step(1'b1, 7'h00, 1'b0, 1'b0);
        idle(12);
        step(1'b1, 7'h01, 1'b0, 1'b0);  // back to back right at the end
        idle(14);
        step(1'b1, 7'h01, 1'b0, 1'b0);
        step(1'b1, 7'h01, 1'b0, 1'b0);
        idle(20);

        cur = "R5";                     // several domains in one write
        step(1'b1, 7'h06, 1'b0, 1'b0);
        idle(7);
        step(1'b1, 7'h01, 1'b0, 1'b0);
        idle(20);

        cur = "R6";                     // memory level held until cleared
        step(1'b1, 7'h08, 1'b0, 1'b0);
        idle(30);
        step(1'b1, 7'h00, 1'b0, 1'b0);
        idle(2);

        cur = "R7";                     // every mix width code
        for (int c = 0; c < 4; c++) begin
            step(1'b1, 7'(c << 4), 1'b0, 1'b0);
            step(1'b0, '0, 1'b1, 1'b0);
            idle((c + 1) * UNIT + 3);
        end

        cur = "R8";                     // code written with the trigger, then mid pulse
        step(1'b1, 7'h00, 1'b0, 1'b0);
        step(1'b1, 7'h30, 1'b1, 1'b0);
        idle(40);
        step(1'b1, 7'h10, 1'b0, 1'b0);
        idle(60);
        step(1'b0, '0, 1'b1, 1'b0);
        idle(2 * UNIT + 3);

        cur = "R9";                     // trigger during a running stretch
        step(1'b0, '0, 1'b1, 1'b0);
        idle(30);
        step(1'b0, '0, 1'b1, 1'b0);
        idle(2 * UNIT + 3);

        cur = "R10";                    // power-gate debug path and mask
        step(1'b1, 7'h00, 1'b0, 1'b0);
        step(1'b0, '0, 1'b0, 1'b1);
        idle(18);
        step(1'b1, 7'h40, 1'b0, 1'b0);
        step(1'b0, '0, 1'b0, 1'b1);
        idle(3);
        step(1'b1, 7'h00, 1'b0, 1'b1);  // unmask in the same cycle: old mask wins
        idle(3);
        step(1'b1, 7'h40, 1'b0, 1'b1);  // mask in the same cycle: pulse still starts
        idle(18);

        cur = "R11";                    // every field at once, readback layout
        step(1'b1, 7'h7F, 1'b1, 1'b0);
        idle(10);
        step(1'b1, 7'h2A, 1'b0, 1'b0);
        idle(UNIT * 4);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule